// File: doc/BRIEF.md
# Page Load and Program Timer

This block gathers single-byte load events into a page buffer and then commits the page to a behavioural byte array. The first accepted load fixes the target page. Each load writes its byte at the offset given by the low address bits, and loads may arrive in any order. The loading phase has no byte count. It ends when no further load arrives within a programmable window of clock cycles.

A program cycle of fixed length then follows. It copies the whole page into the array. Any offset that received no byte is written as zero. While the program cycle runs, new loads are refused. Reads during this time return a status byte instead of array contents: bit 7 is the inverse of bit 7 of the last loaded byte, bit 6 flips on every read, and bits 5..0 carry the last loaded byte's low bits. A host polls either bit until real data comes back.

Top module: `page_prog_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy` and `page_err` are 0 and `rd_data` is 8'h00.
- R2: `busy` rises in the cycle after the first accepted load. It stays high through the load window and the program cycle.
- R3: An address is split into page = `ld_addr[AW-1:6]` and offset = `ld_addr[5:0]`. Bytes of one page may be loaded in any order. If the same offset is loaded twice, the later value is the one programmed.
- R4: A load made during the load window to a page other than the captured page is ignored. It alters neither array page, and `page_err` is 1 for exactly the one cycle after that load.
- R5: A load arriving within WIN_CYC cycles of the previous accepted load extends the window. After WIN_CYC idle cycles, programming starts in the next cycle.
- R6: The program cycle lasts PROG_CYC cycles, or 64 if PROG_CYC is smaller. `busy` is low in the following cycle. Loads during the program cycle are ignored.
- R7: Every offset of the programmed page that was not loaded in that window reads back as 8'h00.
- R8: A read issued during the program cycle returns bit 7 = inverse of bit 7 of the last accepted byte and bits 5..0 = that byte's bits 5..0. This holds at any address.
- R9: Status bit 6 is 0 on the first read of a program cycle and inverts on each later read in that cycle.
- R10: `rd_data` updates one cycle after `rd_en` and otherwise holds. Outside the program cycle it returns the array byte at `rd_addr`, including during the load window.
- R11: A program cycle writes only the captured page. Other pages keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | One-cycle byte-load event |
| ld_addr | input | PAGE_W+6 | Load address (page, offset) |
| ld_data | input | 8 | Load byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | PAGE_W+6 | Read address |
| rd_data | output | 8 | Registered read result, array byte or status |
| busy | output | 1 | High from first load until the program cycle ends |
| page_err | output | 1 | One-cycle pulse after a load to a foreign page was dropped |

## Verification
The bench builds the block with PAGE_W=3, WIN_CYC=8 and PROG_CYC=80. An 80-cycle program cycle is long enough to hold several status reads and a refused load. The short window lets the bench place a load exactly on the last accepting cycle, and place a read on the final window cycle and then on the first program cycle. Eight pages keep the array small while still leaving room to show that one page's program cycle leaves another untouched.

// File: rtl/pgprog_pkg.sv
package pgprog_pkg;
  typedef enum logic [1:0] {PG_IDLE, PG_LOAD, PG_PROG} pg_state_t;
  localparam int DW = 8;
endpackage

// File: rtl/pg_seq.sv
module pg_seq
  import pgprog_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int OFS_W    = 6,
  parameter int WIN_CYC  = 8,
  parameter int PROG_CYC = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic              rd_en,
  output logic              accept,
  output logic              prog_we,
  output logic [OFS_W-1:0]  prog_idx,
  output logic [PAGE_W-1:0] cur_page,
  output logic              clr_mask,
  output logic              in_prog,
  output logic              tog,
  output logic              busy,
  output logic              page_err
);
  localparam int BYTES    = 1 << OFS_W;
  localparam int PROG_LEN = (PROG_CYC < BYTES) ? BYTES : PROG_CYC;
  localparam int WCW      = $clog2(WIN_CYC + 1);
  localparam int PCW      = $clog2(PROG_LEN + 1);

  pg_state_t       st_q, st_d;
  logic [WCW-1:0]  win_q;
  logic [PCW-1:0]  pc_q;
  logic            window_done, prog_last;

  always_comb begin
    accept      = ld_valid && (st_q == PG_IDLE ||
                  (st_q == PG_LOAD && ld_page == cur_page));
    window_done = (st_q == PG_LOAD) && !accept && (win_q == WCW'(WIN_CYC - 1));
    prog_last   = (st_q == PG_PROG) && (pc_q == PCW'(PROG_LEN - 1));
    in_prog     = (st_q == PG_PROG);
    prog_we     = in_prog && (pc_q < PCW'(BYTES));
    prog_idx    = pc_q[OFS_W-1:0];
    clr_mask    = prog_last;
    st_d        = st_q;
    case (st_q)
      PG_IDLE: if (accept)      st_d = PG_LOAD;
      PG_LOAD: if (window_done) st_d = PG_PROG;
      PG_PROG: if (prog_last)   st_d = PG_IDLE;
      default:                  st_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PG_IDLE;
      busy     <= 1'b0;
      page_err <= 1'b0;
      cur_page <= '0;
      win_q    <= '0;
      pc_q     <= '0;
      tog      <= 1'b0;
    end else begin
      st_q     <= st_d;
      busy     <= (st_d != PG_IDLE);
      page_err <= ld_valid && (st_q == PG_LOAD) && (ld_page != cur_page);
      if (st_q == PG_IDLE && accept) cur_page <= ld_page;
      if (accept)                    win_q <= '0;
      else if (st_q == PG_LOAD)      win_q <= win_q + WCW'(1);
      if (st_q != PG_PROG)           pc_q <= '0;
      else                           pc_q <= pc_q + PCW'(1);
      if (st_q != PG_PROG)           tog <= 1'b0;
      else if (rd_en)                tog <= ~tog;
    end
  end

  p_win_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == PG_LOAD) |-> (win_q < WCW'(WIN_CYC)));
  p_prog_step_r6: assert property (@(posedge clk) disable iff (rst)
    (in_prog && $past(in_prog)) |-> (pc_q == $past(pc_q) + PCW'(1)));
  p_err_src_r4: assert property (@(posedge clk) disable iff (rst)
    page_err |-> ($past(ld_valid) && $past(busy)));
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(accept));
  p_tog_flip_r9: assert property (@(posedge clk) disable iff (rst)
    (in_prog && $past(in_prog && rd_en)) |-> (tog != $past(tog)));
endmodule

// File: rtl/pg_pagebuf.sv
module pg_pagebuf
  import pgprog_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [OFS_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             clr,
  input  logic [OFS_W-1:0] ridx,
  output logic [DW-1:0]    rbyte,
  output logic [DW-1:0]    last_byte
);
  localparam int BYTES = 1 << OFS_W;

  logic [DW-1:0]    bytes_q [BYTES];
  logic [BYTES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (we) bytes_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      last_byte <= '0;
    end else begin
      if (clr)     valid_q        <= '0;
      else if (we) valid_q[waddr] <= 1'b1;
      if (we)      last_byte      <= wdata;
    end
  end

  always_comb rbyte = valid_q[ridx] ? bytes_q[ridx] : '0;

  p_mask_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (valid_q == '0));
endmodule

// File: rtl/pg_array.sv
module pg_array
  import pgprog_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  input  logic          stat_sel,
  input  logic [DW-1:0] stat_byte,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= stat_sel ? stat_byte : mem_q[raddr];
  end

  p_stat_read_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && stat_sel) |-> (rd_data == $past(stat_byte)));
  p_read_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: rtl/page_prog_ctl.sv
module page_prog_ctl
  import pgprog_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int OFS_W    = 6,
  parameter int WIN_CYC  = 8,
  parameter int PROG_CYC = 80
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  input  logic [PAGE_W+OFS_W-1:0] ld_addr,
  input  logic [7:0]              ld_data,
  input  logic                    rd_en,
  input  logic [PAGE_W+OFS_W-1:0] rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy,
  output logic                    page_err
);
  localparam int AW = PAGE_W + OFS_W;

  logic              accept, prog_we, clr_mask, in_prog, tog;
  logic [OFS_W-1:0]  prog_idx;
  logic [PAGE_W-1:0] cur_page;
  logic [DW-1:0]     page_byte, last_byte, stat_byte;

  pg_seq #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_page(ld_addr[AW-1:OFS_W]),
    .rd_en(rd_en), .accept(accept), .prog_we(prog_we), .prog_idx(prog_idx),
    .cur_page(cur_page), .clr_mask(clr_mask), .in_prog(in_prog), .tog(tog),
    .busy(busy), .page_err(page_err)
  );

  pg_pagebuf #(.OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst(rst), .we(accept), .waddr(ld_addr[OFS_W-1:0]),
    .wdata(ld_data), .clr(clr_mask), .ridx(prog_idx), .rbyte(page_byte),
    .last_byte(last_byte)
  );

  always_comb stat_byte = {~last_byte[7], tog, last_byte[5:0]};

  pg_array #(.AW(AW)) u_arr (
    .clk(clk), .rst(rst), .we(prog_we), .waddr({cur_page, prog_idx}),
    .wdata(page_byte), .rd_en(rd_en), .raddr(rd_addr), .stat_sel(in_prog),
    .stat_byte(stat_byte), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_page_prog_ctl.sv
module tb_page_prog_ctl;
  localparam int CLK_P    = 10;
  localparam int PAGE_W   = 3;
  localparam int OFS_W    = 6;
  localparam int WIN_CYC  = 8;
  localparam int PROG_CYC = 80;
  localparam int AW       = PAGE_W + OFS_W;
  localparam int BYTES    = 64;
  localparam int NVEC     = 8;
  // {offset, data, idle cycles after the load}
  localparam logic [21:0] VEC [NVEC] = '{
    {6'd37, 8'h5A, 8'd0}, {6'd3,  8'h81, 8'd2}, {6'd63, 8'hFF, 8'd7},
    {6'd0,  8'h12, 8'd1}, {6'd20, 8'hC7, 8'd3}, {6'd3,  8'h44, 8'd0},
    {6'd45, 8'h6E, 8'd5}, {6'd11, 8'h90, 8'd0}
  };

  logic          clk = 1'b0, rst = 1'b1, ld_valid = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [7:0]    ld_data = '0;
  logic [7:0]    rd_data;
  logic          busy, page_err;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  page_prog_ctl #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
  ) dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .page_err(page_err)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(int pg, int ofs, logic [7:0] d);
    ld_valid = 1'b1; ld_addr = AW'(pg * BYTES + ofs); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_read(int pg, int ofs, output logic [7:0] q);
    rd_en = 1'b1; rd_addr = AW'(pg * BYTES + ofs);
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] mdl [BYTES];
    logic [7:0] q, last;
    for (int i = 0; i < BYTES; i++) mdl[i] = 8'h00;
    last = 8'h00;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {7'd0, busy}, 8'h00);
    chk("R1 page_err in reset", {7'd0, page_err}, 8'h00);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);

    // Table walk on page 2: scrambled order, one repeat offset, gaps up to WIN_CYC-1
    for (int v = 0; v < NVEC; v++) begin
      do_load(2, int'(VEC[v][21:16]), VEC[v][15:8]);
      mdl[VEC[v][21:16]] = VEC[v][15:8];
      last = VEC[v][15:8];
      if (v == 0) chk("R2 busy after first load", {7'd0, busy}, 8'h01);
      repeat (int'(VEC[v][7:0])) @(negedge clk);
    end
    repeat (WIN_CYC) @(negedge clk);
    chk("R2 busy in program", {7'd0, busy}, 8'h01);
    do_read(0, 0, q);
    chk("R8 R9 first status", q, {~last[7], 1'b0, last[5:0]});
    do_read(4, 7, q);
    chk("R9 second status", q, {~last[7], 1'b1, last[5:0]});
    do_read(2, 3, q);
    chk("R9 third status", q, {~last[7], 1'b0, last[5:0]});
    wait_idle();
    chk("R6 busy low after program", {7'd0, busy}, 8'h00);
    chk("R4 no page_err", {7'd0, page_err}, 8'h00);
    for (int i = 0; i < BYTES; i++) begin
      do_read(2, i, q);
      chk($sformatf("R3 R7 page2 offset %0d", i), q, mdl[i]);
    end

    // Window edge, read on the last window cycle, refused load in program
    do_load(2, 0, 8'hA5);
    repeat (WIN_CYC - 1) @(negedge clk);
    do_load(2, 1, 8'h3C);
    repeat (WIN_CYC - 1) @(negedge clk);
    do_read(2, 20, q);
    chk("R5 R10 array data on last window cycle", q, 8'hC7);
    do_read(2, 20, q);
    chk("R5 R8 status on first program cycle", q, 8'hBC);
    do_read(2, 20, q);
    chk("R9 toggled status", q, 8'hFC);
    do_load(2, 7, 8'h99);
    repeat (PROG_CYC - 4) @(negedge clk);
    chk("R6 busy on last program cycle", {7'd0, busy}, 8'h01);
    @(negedge clk);
    chk("R6 busy low right after program", {7'd0, busy}, 8'h00);
    do_read(2, 0, q);  chk("R5 first byte kept", q, 8'hA5);
    do_read(2, 1, q);  chk("R5 edge load kept", q, 8'h3C);
    do_read(2, 7, q);  chk("R6 load during program ignored", q, 8'h00);
    do_read(2, 20, q); chk("R7 unloaded offset cleared", q, 8'h00);
    chk("R10 rd_data holds", rd_data, 8'h00);

    // Foreign page load and page isolation
    do_load(5, 9, 8'h66);
    wait_idle();
    do_load(2, 9, 8'h11);
    do_load(5, 9, 8'h77);
    chk("R4 page_err pulse", {7'd0, page_err}, 8'h01);
    @(negedge clk);
    chk("R4 page_err one cycle", {7'd0, page_err}, 8'h00);
    wait_idle();
    do_read(5, 9, q);  chk("R4 R11 foreign page untouched", q, 8'h66);
    do_read(2, 9, q);  chk("R3 captured page written", q, 8'h11);
    do_read(2, 1, q);  chk("R7 earlier byte cleared", q, 8'h00);
    do_read(5, 10, q); chk("R11 other page unloaded byte", q, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all: watchdog expired, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule